// File: doc/BRIEF.md
# Function Configuration Header Register File

This block stores the 64-byte type-0 configuration header of one PCI device function and answers size-qualified reads and writes addressed by byte offset. Each access carries a size of 1, 2 or 4 bytes. The block checks every access against a fixed table of writable registers. It applies the special rules of the base address registers (BARs) and of the expansion ROM register, and it returns read data one cycle after the request. Any access it refuses produces a one-cycle error pulse instead.

Probe software finds the size of a BAR by writing all ones to it and reading the result back. The block answers with a mask built from the BAR's size parameter, and the BAR's read-only type bits are unchanged. The block also reports each BAR's programmed base address and a sticky flag that shows whether that base was ever assigned. Glue logic that maps the function into the system address space uses these two outputs. The reset contents of the header and the six BAR sizes are parameters.

Top module: `cfg_space_regs`

## Requirements
- R1: After reset, every 4-byte read at offset 4*k (k = 0..15) returns word k of the reset-contents parameter, and all `bar_assigned` bits and `bar_base` values are zero.
- R2: A legal read raises `rd_valid` for exactly one cycle, one clock edge after the request. `rd_data` holds the bytes starting at the offset in little-endian order, right-aligned, and its unused upper bytes are zero.
- R3: An access is refused if any of the following holds: its size is not 1, 2 or 4; its offset is not a multiple of its size; or its offset is 0x40 or above. A refused access raises `acc_err` for one cycle, one edge later. It does not raise `rd_valid` and it changes no stored state.
- R4: A 1-byte write is accepted only at offsets 0x0C, 0x0D and 0x3C, and it replaces that one byte. A 1-byte write anywhere else is refused as in R3.
- R5: A 2-byte write is accepted only at offsets 0x04, 0x06 and 0x0C, and it replaces those two bytes. A 2-byte write anywhere else is refused as in R3.
- R6: A 4-byte write at offset 0x04 replaces only bytes 0x04-0x05. Bytes 0x06-0x07 keep their value.
- R7: BAR i occupies offset 0x10+4*i, for i = 0..5. If the stored bit 0 is 1, the BAR is an I/O BAR and bits 1:0 are read-only. Otherwise it is a memory BAR and bits 3:0 are read-only. An ordinary 4-byte write replaces only the bits above the read-only field.
- R8: A 4-byte write of 0xFFFFFFFF to BAR i stores ~(size_i - 1) in the writable bits and keeps the read-only bits.
- R9: An ordinary write to BAR i sets `bar_base[32*i+:32]` to the written value with the read-only field cleared, and sets `bar_assigned[i]`, but only when that cleared value is nonzero. Sizing writes and zero-base writes leave both outputs unchanged, and only reset clears `bar_assigned`.
- R10: A 4-byte write of 0xFFFFFFFE at offset 0x30 makes that word read 0xFFFFFFFF. Any other value written there is stored as given.
- R11: A 4-byte write to any other in-range aligned offset is refused: it raises `acc_err` and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 8 | Byte offset into configuration space |
| acc_size | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| acc_wdata | input | 32 | Write data, right-aligned |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 32 | Read data, right-aligned |
| acc_err | output | 1 | Refused-access pulse |
| bar_base | output | 192 | Programmed base of each BAR, 32 bits per BAR |
| bar_assigned | output | 6 | Sticky per-BAR base-assigned flag |

## Verification
The bench targets the cases listed below and names the fault each one exposes.
- **Type bits during sizing.** It sizes BARs of both types. A design that masked the wrong width of low bits, or that overwrote the type bits during sizing, would return a wrong mask.
- **Accepted and refused writes.** It sends narrow writes at every accepted offset and at neighbouring refused ones. It also sends a 4-byte write to the command word. A loose permission table would corrupt the identity or status bytes, and a missing byte-lane mask would change the status half.
- **Base tracking.** It writes zero-base values to BARs, which must not set the assigned flag, and it checks that a sizing write leaves the reported base alone.
- **Refused accesses.** It sends odd sizes, misaligned offsets and offsets past the header. These must pulse `acc_err` without producing read data.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int HDR_WORDS = 16;
  localparam int NUM_BARS  = 6;
  localparam int WORD_W    = 32;
  localparam int OFF_W     = 8;

  localparam logic [7:0] OFF_CMD      = 8'h04;
  localparam logic [7:0] OFF_STAT     = 8'h06;
  localparam logic [7:0] OFF_CLS      = 8'h0C;
  localparam logic [7:0] OFF_LAT      = 8'h0D;
  localparam logic [7:0] OFF_BAR_LO   = 8'h10;
  localparam logic [7:0] OFF_BAR_HI   = 8'h10 + 8'(4 * (NUM_BARS - 1));
  localparam logic [7:0] OFF_ROM      = 8'h30;
  localparam logic [7:0] OFF_IRQ_LINE = 8'h3C;
  localparam logic [3:0] BAR_WORD0    = 4'(OFF_BAR_LO >> 2);

  typedef enum logic [1:0] {
    WK_BYTES = 2'd0,
    WK_BAR   = 2'd1,
    WK_ROM   = 2'd2
  } wkind_e;
endpackage

// File: rtl/cfg_access_decode.sv
module cfg_access_decode
  import cfg_pkg::*;
(
  input  logic        write,
  input  logic [7:0]  off,
  input  logic [2:0]  size,
  input  logic [31:0] wdata,
  output logic        ok,
  output wkind_e      kind,
  output logic [3:0]  word,
  output logic [3:0]  be,
  output logic [31:0] wdata_al
);
  logic size_ok, align_ok, range_ok;

  always_comb begin
    size_ok  = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
    align_ok = (off[1:0] & (size[1:0] - 2'd1)) == 2'd0;
    range_ok = (off[7:6] == 2'b00);
    word     = off[5:2];
    wdata_al = wdata << {off[1:0], 3'b000};
    kind     = WK_BYTES;
    be       = 4'b0000;
    ok       = 1'b0;
    if (size_ok && align_ok && range_ok) begin
      if (!write) begin
        ok = 1'b1;
      end else begin
        unique case (size)
          3'd1: begin
            ok = (off == OFF_CLS) || (off == OFF_LAT) || (off == OFF_IRQ_LINE);
            be = 4'b0001 << off[1:0];
          end
          3'd2: begin
            ok = (off == OFF_CMD) || (off == OFF_STAT) || (off == OFF_CLS);
            be = 4'b0011 << off[1:0];
          end
          default: begin
            if (off >= OFF_BAR_LO && off <= OFF_BAR_HI) begin
              ok   = 1'b1;
              kind = WK_BAR;
            end else if (off == OFF_ROM) begin
              ok   = 1'b1;
              kind = WK_ROM;
            end else if (off == OFF_CMD) begin
              ok = 1'b1;
              be = 4'b0011;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot #(
  parameter logic [31:0] SIZE = 32'h0000_1000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sel,
  input  logic [31:0] wdata,
  input  logic [31:0] cur,
  output logic [31:0] nxt,
  output logic [31:0] base,
  output logic        assigned
);
  logic [31:0] ro_mask, upper, cand;
  logic        sizing;

  always_comb begin
    ro_mask = cur[0] ? 32'h0000_0003 : 32'h0000_000F;
    sizing  = (wdata == 32'hFFFF_FFFF);
    upper   = sizing ? ~(SIZE - 32'd1) : wdata;
    nxt     = (upper & ~ro_mask) | (cur & ro_mask);
    cand    = wdata & ~ro_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base     <= '0;
      assigned <= 1'b0;
    end else if (sel && !sizing && cand != 32'd0) begin
      base     <= cand;
      assigned <= 1'b1;
    end
  end

  p_type_bit_kept_r7: assert property (@(posedge clk) disable iff (rst)
    $stable(cur[0]));
  p_assigned_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    !$fell(assigned));
  p_sizing_keeps_base_r8: assert property (@(posedge clk) disable iff (rst)
    (sel && sizing) |=> $stable(base));
endmodule

// File: rtl/cfg_space_regs.sv
module cfg_space_regs
  import cfg_pkg::*;
#(
  parameter logic [HDR_WORDS*WORD_W-1:0] HDR_INIT = {
    32'h0000_0100, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000,
    32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000,
    32'h0000_0000, 32'h0000_0008, 32'h0000_0000, 32'h0000_0001,
    32'h0000_4010, 32'h0200_0001, 32'h0210_0000, 32'h5A17_1D0F},
  parameter logic [NUM_BARS*WORD_W-1:0] BAR_SIZES = {
    32'h0000_0000, 32'h0000_0040, 32'h0000_0000,
    32'h0010_0000, 32'h0000_1000, 32'h0000_0100}
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       acc_valid,
  input  logic                       acc_write,
  input  logic [OFF_W-1:0]           acc_offset,
  input  logic [2:0]                 acc_size,
  input  logic [WORD_W-1:0]          acc_wdata,
  output logic                       rd_valid,
  output logic [WORD_W-1:0]          rd_data,
  output logic                       acc_err,
  output logic [NUM_BARS*WORD_W-1:0] bar_base,
  output logic [NUM_BARS-1:0]        bar_assigned
);
  logic [WORD_W-1:0] mem [HDR_WORDS];
  logic              ok;
  wkind_e            kind;
  logic [3:0]        word, be;
  logic [WORD_W-1:0] wdata_al, rd_word, rd_shift;
  logic [WORD_W-1:0] bar_nxt [NUM_BARS];
  logic [3:0]        bar_idx;
  logic              do_write;

  cfg_access_decode u_dec (
    .write(acc_write), .off(acc_offset), .size(acc_size), .wdata(acc_wdata),
    .ok(ok), .kind(kind), .word(word), .be(be), .wdata_al(wdata_al)
  );

  assign do_write = acc_valid && acc_write && ok;
  assign bar_idx  = word - BAR_WORD0;

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
    cfg_bar_slot #(.SIZE(BAR_SIZES[i*WORD_W +: WORD_W])) u_slot (
      .clk(clk), .rst(rst),
      .sel(do_write && kind == WK_BAR && bar_idx == 4'(i)),
      .wdata(acc_wdata),
      .cur(mem[BAR_WORD0 + 4'(i)]),
      .nxt(bar_nxt[i]),
      .base(bar_base[i*WORD_W +: WORD_W]),
      .assigned(bar_assigned[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < HDR_WORDS; k++) mem[k] <= HDR_INIT[k*WORD_W +: WORD_W];
    end else if (do_write) begin
      unique case (kind)
        WK_BAR: mem[word] <= bar_nxt[bar_idx[2:0]];
        WK_ROM: mem[word] <= (acc_wdata == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : acc_wdata;
        default: begin
          for (int b = 0; b < 4; b++)
            if (be[b]) mem[word][8*b +: 8] <= wdata_al[8*b +: 8];
        end
      endcase
    end
  end

  always_comb begin
    rd_word  = mem[word];
    rd_shift = rd_word >> {acc_offset[1:0], 3'b000};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      acc_err  <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_valid && !acc_write && ok;
      acc_err  <= acc_valid && !ok;
      if (acc_valid && !acc_write && ok) begin
        unique case (acc_size)
          3'd1:    rd_data <= {24'd0, rd_shift[7:0]};
          3'd2:    rd_data <= {16'd0, rd_shift[15:0]};
          default: rd_data <= rd_shift;
        endcase
      end
    end
  end

  p_rd_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(acc_valid && !acc_write));
  p_err_follows_req_r3: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> $past(acc_valid));
  p_err_not_rd_r3: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && acc_err));
  p_id_word_const_r11: assert property (@(posedge clk) disable iff (rst)
    $stable(mem[0]));
endmodule

// File: tb/tb_cfg_space_regs.sv
`timescale 1ns/1ps
module tb_cfg_space_regs;
  localparam int CLK_NS = 20;
  localparam logic [511:0] INIT = {
    32'h0000_0100, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000,
    32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000,
    32'h0000_0000, 32'h0000_0008, 32'h0000_0000, 32'h0000_0001,
    32'h0000_4010, 32'h0200_0001, 32'h0210_0000, 32'h5A17_1D0F};
  localparam logic [191:0] SIZES = {
    32'h0000_0000, 32'h0000_0040, 32'h0000_0000,
    32'h0010_0000, 32'h0000_1000, 32'h0000_0100};

  logic clk = 0, rst = 1;
  logic acc_valid = 0, acc_write = 0;
  logic [7:0] acc_offset = 0;
  logic [2:0] acc_size = 0;
  logic [31:0] acc_wdata = 0;
  logic rd_valid, acc_err;
  logic [31:0] rd_data;
  logic [191:0] bar_base;
  logic [5:0] bar_assigned;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_mem [16];
  logic [31:0] m_base [6];
  logic [5:0]  m_asg;

  always #(CLK_NS/2) clk = ~clk;

  cfg_space_regs #(.HDR_INIT(INIT), .BAR_SIZES(SIZES)) dut (.*);

  task automatic check(input bit good, input string tag, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_byte(input int o);
    return m_mem[o/4][8*(o%4) +: 8];
  endfunction

  // Expected-value model written from the requirements
  task automatic model(input bit w, input logic [7:0] o, input logic [2:0] s, input logic [31:0] d,
                       output bit e_err, output bit e_rv, output logic [31:0] e_rd);
    bit legal;
    int n;
    legal = (s == 1 || s == 2 || s == 4) && (int'(o) % int'(s == 0 ? 1 : s) == 0) && o < 8'h40;
    e_rd = 0; e_rv = 0; e_err = 0;
    if (!legal) begin e_err = 1; return; end
    if (!w) begin
      e_rv = 1;
      for (int b = 0; b < int'(s); b++) e_rd[8*b +: 8] = m_byte(o + b);
      return;
    end
    n = int'(o) / 4;
    if (s == 1 && (o == 8'h0C || o == 8'h0D || o == 8'h3C))
      m_mem[n][8*(o%4) +: 8] = d[7:0];
    else if (s == 2 && (o == 8'h04 || o == 8'h06 || o == 8'h0C))
      m_mem[n][8*(o%4) +: 16] = d[15:0];
    else if (s == 4 && o == 8'h04)
      m_mem[1][15:0] = d[15:0];
    else if (s == 4 && o == 8'h30)
      m_mem[12] = (d == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : d;
    else if (s == 4 && o >= 8'h10 && o <= 8'h24) begin
      int i;
      logic [31:0] msk, sz;
      i = (int'(o) - 16) / 4;
      msk = m_mem[n][0] ? 32'h3 : 32'hF;
      sz = SIZES[32*i +: 32];
      if (d == 32'hFFFF_FFFF)
        m_mem[n] = (~(sz - 1) & ~msk) | (m_mem[n] & msk);
      else begin
        m_mem[n] = (d & ~msk) | (m_mem[n] & msk);
        if ((d & ~msk) != 0) begin m_base[i] = d & ~msk; m_asg[i] = 1; end
      end
    end else e_err = 1;
  endtask

  task automatic access(input bit w, input logic [7:0] o, input logic [2:0] s,
                        input logic [31:0] d, input string tag);
    bit e_err, e_rv;
    logic [31:0] e_rd;
    logic [191:0] eb;
    model(w, o, s, d, e_err, e_rv, e_rd);
    @(negedge clk);
    acc_valid = 1; acc_write = w; acc_offset = o; acc_size = s; acc_wdata = d;
    @(negedge clk);
    acc_valid = 0;
    check(acc_err == e_err && rd_valid == e_rv, {tag, " flags"}, {acc_err, rd_valid}, {e_err, e_rv});
    if (e_rv) check(rd_data == e_rd, {tag, " data"}, rd_data, e_rd);
    for (int i = 0; i < 6; i++) eb[32*i +: 32] = m_base[i];
    check(bar_base == eb && bar_assigned == m_asg, {tag, " bar outputs"}, {bar_assigned, bar_base}, {m_asg, eb});
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C1F));
    for (int k = 0; k < 16; k++) m_mem[k] = INIT[32*k +: 32];
    for (int i = 0; i < 6; i++) m_base[i] = 0;
    m_asg = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset contents
    for (int k = 0; k < 16; k++) access(0, 8'(4*k), 3'd4, 0, "R1 reset read");
    // R2 narrow reads
    access(0, 8'h02, 3'd1, 0, "R2 byte read");
    access(0, 8'h06, 3'd2, 0, "R2 half read");
    access(0, 8'h0D, 3'd1, 0, "R2 byte read lane1");
    // R3 refused accesses
    access(0, 8'h00, 3'd3, 0, "R3 size three");
    access(0, 8'h05, 3'd2, 0, "R3 misaligned");
    access(0, 8'h40, 3'd4, 0, "R3 out of range");
    access(1, 8'h44, 3'd4, 32'h1111_1111, "R3 write out of range");
    // R4 byte writes
    access(1, 8'h3C, 3'd1, 32'h0000_005A, "R4 irq line write");
    access(1, 8'h0D, 3'd1, 32'h0000_0077, "R4 latency write");
    access(1, 8'h00, 3'd1, 32'h0000_00EE, "R4 refused byte");
    access(0, 8'h3C, 3'd4, 0, "R4 readback");
    access(0, 8'h00, 3'd4, 0, "R4 id untouched");
    // R5 half writes
    access(1, 8'h06, 3'd2, 32'h0000_BEEF, "R5 status write");
    access(1, 8'h08, 3'd2, 32'h0000_1234, "R5 refused half");
    access(0, 8'h04, 3'd4, 0, "R5 readback");
    // R6 command word
    access(1, 8'h04, 3'd4, 32'hDEAD_C0DE, "R6 cmd 4B write");
    access(0, 8'h04, 3'd4, 0, "R6 status kept");
    // R7 / R9 BAR programming
    access(1, 8'h10, 3'd4, 32'h1234_5677, "R7 io bar write");
    access(0, 8'h10, 3'd4, 0, "R7 io bar read");
    access(1, 8'h18, 3'd4, 32'h0000_0007, "R9 zero base no assign");
    access(1, 8'h18, 3'd4, 32'h0020_0000, "R9 mem base assign");
    access(1, 8'h10, 3'd4, 32'h0000_8001, "R9 base update");
    // R8 sizing
    access(1, 8'h14, 3'd4, 32'hFFFF_FFFF, "R8 size mem bar");
    access(0, 8'h14, 3'd4, 0, "R8 mem size mask");
    access(1, 8'h10, 3'd4, 32'hFFFF_FFFF, "R8 size io bar");
    access(0, 8'h10, 3'd4, 0, "R8 io size mask");
    access(1, 8'h1C, 3'd4, 32'hFFFF_FFFF, "R8 size empty bar");
    access(0, 8'h1C, 3'd4, 0, "R8 empty mask");
    // R10 expansion ROM
    access(1, 8'h30, 3'd4, 32'hFFFF_FFFE, "R10 rom sizing");
    access(0, 8'h30, 3'd4, 0, "R10 rom reads ones");
    access(1, 8'h30, 3'd4, 32'h1234_0001, "R10 rom plain");
    access(0, 8'h30, 3'd4, 0, "R10 rom readback");
    // R11 other 4B writes
    access(1, 8'h08, 3'd4, 32'hCAFE_F00D, "R11 class write refused");
    access(1, 8'h3C, 3'd4, 32'hCAFE_F00D, "R11 irq word refused");
    access(0, 8'h08, 3'd4, 0, "R11 readback");
    // Random mix
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] d;
      logic [7:0] o;
      int pick;
      pick = $urandom_range(0, 4);
      d = (pick == 0) ? 32'hFFFF_FFFF : (pick == 1) ? 32'hFFFF_FFFE :
          (pick == 2) ? 32'($urandom_range(0, 31)) : $urandom;
      o = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 8'h47)) : 8'(4 * $urandom_range(0, 15));
      access(1'($urandom_range(0, 1)), o, 3'($urandom_range(0, 5)), d, "R3 R7 R8 R9 random mix");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule